// File: doc/BRIEF.md
# Triggered Signal Trace Capture Buffer

This block records a short history of one internal 32-bit signal group for debug. A control register picks one of sixteen source lanes on a flat input bus. Every word that gets stored is that lane ANDed with a dump mask. Storage is a 32-word circular buffer. Three recording policies exist: record on every cycle, start recording when a trigger fires and stop once the buffer is full, or record until a trigger fires and keep the samples that came before it. The trigger compares the masked lane against a masked reference value. It can fire on a level match, on a level mismatch, or on the cycle where a mismatch turns into a match.

Software works with the block through a small word-addressed register port. It sets the halt bit before it changes the configuration or reads out the buffer. It drains the buffer through one data address that moves forward by one entry on each read and returns the oldest word first. Any write to the control register that leaves the halt bit clear restarts capture: it empties the buffer, resets the read position and re-arms the trigger.

Top module: `trace_capture`

## Requirements
- R1: Word addresses are 0 = control, 1 = trigger value, 2 = trigger mask, 3 = dump mask and 4 = captured data. Control bits 2:0 hold the trigger mode, bits 5:3 the dump mode, bits 9:6 the source select and bit 10 the halt flag. Bits above 10 read as zero. The other control fields read back exactly as written, invalid codes included. After reset, control reads 0x409 (halted, record-always, edge), the dump mask reads 0xFFFFFFFF and the trigger value reads 0.
- R2: Each stored word equals source lane `src` (bus bits src*32+31 down to src*32) ANDed with the dump mask.
- R3: With dump mode 3'b001 (record always), a word is stored on every enabled cycle. When full, the buffer overwrites its oldest entry, so it keeps the latest 32 samples.
- R4: With dump mode 3'b010 (after trigger), recording starts on the cycle the trigger fires, includes that sample, and stops once 32 words are stored.
- R5: With dump mode 3'b100 (until trigger), recording runs until the trigger fires. The firing sample is not stored and no later samples are stored.
- R6: The trigger compares (lane AND trigger mask) with (trigger value AND trigger mask). Trigger mode 3'b010 fires on every equal cycle. Trigger mode 3'b100 fires on every unequal cycle.
- R7: Trigger mode 3'b001 fires only on a cycle where the comparison is equal and was unequal on the previous enabled cycle. An equal comparison on the first cycle after restart does not fire.
- R8: While the halt bit is set, no word is stored and changes on the source bus have no effect on the buffer contents.
- R9: Each read of the data address returns the oldest entry not yet read and moves forward by one. Once every stored entry has been read, further data reads return zero.
- R10: Any write to control with the halt bit clear empties the buffer, resets the read position and re-arms the trigger.
- R11: An invalid dump mode (not 001, 010 or 100), or an invalid trigger mode together with a dump mode other than 001, stores nothing. With dump mode 001 the trigger mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and capture |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| sig_bus | input | 512 | Sixteen 32-bit source lanes, lane n at bits n*32+31 down to n*32 |

## Verification
A register read returns its value on the clock edge that follows the read strobe. Each data read moves the read position forward at that same edge. A control write takes effect on the next edge, so the cycle that carries the enabling write captures nothing. The cycle that carries the halting write still captures its sample. The bench drives every input on the falling edge, samples `reg_rdata` on the falling edge after the strobe, and counts exactly which stimulus cycles fall inside the capture window. It then computes the expected words from the lane pattern, the masks and the trigger position.

// File: rtl/trc_pkg.sv
package trc_pkg;

    localparam int unsigned CTRL_W    = 32;
    localparam int unsigned MODE_W    = 3;
    localparam int unsigned SRC_FLD_W = 4;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned HALT_BIT  = 10;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL = 3'd0,
        ADR_TVAL = 3'd1,
        ADR_TMSK = 3'd2,
        ADR_DMSK = 3'd3,
        ADR_DATA = 3'd4
    } reg_sel_e;

    localparam logic [MODE_W-1:0] DUMP_FREE = 3'b001;
    localparam logic [MODE_W-1:0] DUMP_POST = 3'b010;
    localparam logic [MODE_W-1:0] DUMP_PRE  = 3'b100;

    localparam logic [MODE_W-1:0] TRIG_EDGE = 3'b001;
    localparam logic [MODE_W-1:0] TRIG_SAME = 3'b010;
    localparam logic [MODE_W-1:0] TRIG_DIFF = 3'b100;

    typedef struct packed {
        logic [CTRL_W-HALT_BIT-2:0] rsvd;
        logic                       halt;
        logic [SRC_FLD_W-1:0]       src;
        logic [MODE_W-1:0]          dump;
        logic [MODE_W-1:0]          trig;
    } ctrl_t;

    typedef enum logic [1:0] {
        CAP_ARMED = 2'd0,
        CAP_REC   = 2'd1,
        CAP_DONE  = 2'd2
    } cap_state_e;

    localparam ctrl_t CTRL_RESET = '{rsvd: '0, halt: 1'b1, src: '0,
                                     dump: DUMP_FREE, trig: TRIG_EDGE};

    function automatic logic dump_valid(logic [MODE_W-1:0] d);
        return (d == DUMP_FREE) || (d == DUMP_POST) || (d == DUMP_PRE);
    endfunction

    function automatic logic trig_valid(logic [MODE_W-1:0] t);
        return (t == TRIG_EDGE) || (t == TRIG_SAME) || (t == TRIG_DIFF);
    endfunction

    function automatic logic cfg_valid(logic [MODE_W-1:0] d, logic [MODE_W-1:0] t);
        return dump_valid(d) && ((d == DUMP_FREE) || trig_valid(t));
    endfunction

    function automatic ctrl_t ctrl_from_word(logic [CTRL_W-1:0] w);
        ctrl_t c;
        c      = ctrl_t'(w);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/trc_regs.sv
module trc_regs
    import trc_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    output logic                  halt,
    output logic [SRC_FLD_W-1:0]  src,
    output logic [MODE_W-1:0]     dump,
    output logic                  cfg_good,
    output logic [MODE_W-1:0]     trig,
    output logic [WORD_W-1:0]     tval,
    output logic [WORD_W-1:0]     tmsk,
    output logic [WORD_W-1:0]     dmsk,
    output logic                  rearm,
    output logic [WORD_W-1:0]     cfg_rd
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            tval   <= '0;
            tmsk   <= '0;
            dmsk   <= '1;
        end else if (wr_en) begin
            case (addr)
                ADR_CTRL: ctrl_q <= ctrl_from_word(wdata[CTRL_W-1:0]);
                ADR_TVAL: tval   <= wdata;
                ADR_TMSK: tmsk   <= wdata;
                ADR_DMSK: dmsk   <= wdata;
                default:  ;
            endcase
        end
    end

    assign rearm    = wr_en && (addr == ADR_CTRL) && !wdata[HALT_BIT];
    assign halt     = ctrl_q.halt;
    assign src      = ctrl_q.src;
    assign dump     = ctrl_q.dump;
    assign trig     = ctrl_q.trig;
    assign cfg_good = cfg_valid(ctrl_q.dump, ctrl_q.trig);

    always_comb begin
        case (addr)
            ADR_CTRL: cfg_rd = WORD_W'(ctrl_q);
            ADR_TVAL: cfg_rd = tval;
            ADR_TMSK: cfg_rd = tmsk;
            ADR_DMSK: cfg_rd = dmsk;
            default:  cfg_rd = '0;
        endcase
    end

endmodule

// File: rtl/trc_trigger.sv
module trc_trigger
    import trc_pkg::*;
#(
    parameter int unsigned SRC_N  = 16,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned SEL_W = $clog2(SRC_N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SRC_N*WORD_W-1:0] sig_bus,
    input  logic [SEL_W-1:0]        src,
    input  logic [WORD_W-1:0]       tval,
    input  logic [WORD_W-1:0]       tmsk,
    input  logic [MODE_W-1:0]       mode,
    input  logic                    active,
    input  logic                    rearm,
    output logic [WORD_W-1:0]       picked,
    output logic                    fire
);

    logic [WORD_W-1:0] lanes [SRC_N];
    logic              eq_now;
    logic              eq_prev;

    for (genvar g = 0; g < SRC_N; g++) begin : g_lane
        assign lanes[g] = sig_bus[g*WORD_W +: WORD_W];
    end

    assign picked = lanes[src];
    assign eq_now = ((picked ^ tval) & tmsk) == '0;

    // Previous comparison starts "equal" so a match right after restart is no edge.
    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            eq_prev <= 1'b1;
        end else if (active) begin
            eq_prev <= eq_now;
        end
    end

    always_comb begin
        case (mode)
            TRIG_EDGE: fire = eq_now && !eq_prev;
            TRIG_SAME: fire = eq_now;
            TRIG_DIFF: fire = !eq_now;
            default:   fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/trc_ctl.sv
module trc_ctl
    import trc_pkg::*;
#(
    parameter int unsigned DEPTH   = 32,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic [MODE_W-1:0]  dump,
    input  logic               fire,
    input  logic               rearm,
    input  logic               rd_adv,
    output logic               wr_en,
    output logic [PTR_W-1:0]   wr_ptr,
    output logic [PTR_W-1:0]   rd_ptr,
    output logic [CNT_W-1:0]   fill,
    output logic [CNT_W-1:0]   rd_cnt,
    output logic               exhausted,
    output cap_state_e         state
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(DEPTH - 1);

    cap_state_e       nxt;
    logic [CNT_W-1:0] rd_sum;

    always_comb begin
        wr_en = 1'b0;
        nxt   = state;
        if (active) begin
            case (state)
                CAP_ARMED: begin
                    if (dump == DUMP_POST) begin
                        if (fire) begin
                            wr_en = 1'b1;
                            nxt   = (DEPTH == 1) ? CAP_DONE : CAP_REC;
                        end
                    end else if (dump == DUMP_PRE && fire) begin
                        nxt = CAP_DONE;
                    end else begin
                        wr_en = 1'b1;
                    end
                end
                CAP_REC: begin
                    wr_en = 1'b1;
                    if (fill == LAST_C) nxt = CAP_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            state  <= CAP_ARMED;
            wr_ptr <= '0;
            fill   <= '0;
            rd_cnt <= '0;
        end else begin
            state <= nxt;
            if (wr_en) begin
                wr_ptr <= wr_ptr + 1'b1;
                if (fill != FULL_C) fill <= fill + 1'b1;
            end
            if (rd_adv && rd_cnt != FULL_C) rd_cnt <= rd_cnt + 1'b1;
        end
    end

    // Oldest entry sits fill slots behind the write pointer (DEPTH is a power of two).
    assign rd_sum    = {1'b0, wr_ptr} - fill + rd_cnt;
    assign rd_ptr    = rd_sum[PTR_W-1:0];
    assign exhausted = rd_cnt >= fill;

endmodule

// File: rtl/trc_buf.sv
module trc_buf #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trc_pkg::*;
#(
    parameter int unsigned SRC_N     = 16,
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned BUF_DEPTH = 32,
    localparam int unsigned SEL_W    = $clog2(SRC_N),
    localparam int unsigned PTR_W    = $clog2(BUF_DEPTH),
    localparam int unsigned CNT_W    = PTR_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [WORD_W-1:0]       reg_wdata,
    output logic [WORD_W-1:0]       reg_rdata,
    input  logic [SRC_N*WORD_W-1:0] sig_bus
);

    logic                 halt_q;
    logic [SRC_FLD_W-1:0] src_q;
    logic [MODE_W-1:0]    dump_q;
    logic [MODE_W-1:0]    trig_q;
    logic                 cfg_good;
    logic [WORD_W-1:0]    tval_q;
    logic [WORD_W-1:0]    tmsk_q;
    logic [WORD_W-1:0]    dmsk_q;
    logic                 rearm;
    logic [WORD_W-1:0]    cfg_rd;
    logic                 active;
    logic [WORD_W-1:0]    picked;
    logic                 fire;
    logic                 data_rd;
    logic                 wr_en;
    logic [PTR_W-1:0]     wr_ptr;
    logic [PTR_W-1:0]     rd_ptr;
    logic [CNT_W-1:0]     fill;
    logic [CNT_W-1:0]     rd_cnt;
    logic                 exhausted;
    cap_state_e           cap_state;
    logic [WORD_W-1:0]    buf_word;

    trc_regs #(.WORD_W(WORD_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .halt     (halt_q),
        .src      (src_q),
        .dump     (dump_q),
        .cfg_good (cfg_good),
        .trig     (trig_q),
        .tval     (tval_q),
        .tmsk     (tmsk_q),
        .dmsk     (dmsk_q),
        .rearm    (rearm),
        .cfg_rd   (cfg_rd)
    );

    assign active  = !halt_q && cfg_good;
    assign data_rd = reg_rd && (reg_addr == ADR_DATA);

    trc_trigger #(.SRC_N(SRC_N), .WORD_W(WORD_W)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .sig_bus (sig_bus),
        .src     (src_q[SEL_W-1:0]),
        .tval    (tval_q),
        .tmsk    (tmsk_q),
        .mode    (trig_q),
        .active  (active),
        .rearm   (rearm),
        .picked  (picked),
        .fire    (fire)
    );

    trc_ctl #(.DEPTH(BUF_DEPTH)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .dump      (dump_q),
        .fire      (fire),
        .rearm     (rearm),
        .rd_adv    (data_rd),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .fill      (fill),
        .rd_cnt    (rd_cnt),
        .exhausted (exhausted),
        .state     (cap_state)
    );

    trc_buf #(.DEPTH(BUF_DEPTH), .WORD_W(WORD_W)) u_buf (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_ptr (wr_ptr),
        .wdata  (picked & dmsk_q),
        .rd_ptr (rd_ptr),
        .rdata  (buf_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            if (data_rd) reg_rdata <= exhausted ? '0 : buf_word;
            else         reg_rdata <= cfg_rd;
        end
    end

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk
    import trc_pkg::*;
#(
    parameter int unsigned BUF_DEPTH = 32,
    parameter int unsigned WORD_W    = 32,
    localparam int unsigned PTR_W    = $clog2(BUF_DEPTH),
    localparam int unsigned CNT_W    = PTR_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              halt,
    input logic              cfg_good,
    input logic              active,
    input logic              rearm,
    input logic [MODE_W-1:0] dump,
    input logic              fire,
    input logic              data_rd,
    input logic              exhausted,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic [CNT_W-1:0]  fill,
    input logic [CNT_W-1:0]  rd_cnt,
    input cap_state_e        state,
    input logic [WORD_W-1:0] rdata
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(BUF_DEPTH);

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && !rearm) |=> ($stable(wr_ptr) && $stable(fill)));

    // R11
    bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_good && !rearm) |=> ($stable(wr_ptr) && $stable(fill)));

    // R9
    drained_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (data_rd && exhausted) |=> (rdata == '0));

    // R4
    post_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_DONE && !rearm) |=> $stable(wr_ptr));

    // R5
    pre_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (active && dump == DUMP_PRE && fire && !rearm) |=>
            ($stable(wr_ptr) && state == CAP_DONE));

    // R3
    free_run_chk: assert property (@(posedge clk) disable iff (rst)
        (active && dump == DUMP_FREE && !rearm) |=>
            ((fill == FULL_C) || (fill == $past(fill) + CNT_W'(1))));

    // R10
    rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (fill == '0 && rd_cnt == '0));

endmodule

bind trace_capture trace_capture_chk #(.BUF_DEPTH(BUF_DEPTH), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .halt      (halt_q),
    .cfg_good  (cfg_good),
    .active    (active),
    .rearm     (rearm),
    .dump      (dump_q),
    .fire      (fire),
    .data_rd   (data_rd),
    .exhausted (exhausted),
    .wr_ptr    (wr_ptr),
    .fill      (fill),
    .rd_cnt    (rd_cnt),
    .state     (cap_state),
    .rdata     (reg_rdata)
);

// File: tb/trace_capture_tb_top.sv
`timescale 1ns/1ps
module trace_capture_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         reg_wr;
    logic         reg_rd;
    logic [2:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic [511:0] sig_bus;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trace_capture dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sig_bus   (sig_bus)
    );

    function automatic logic [31:0] gen(int s, int k);
        logic [31:0] sv = 32'(s);
        logic [31:0] kv = 32'(k);
        return {sv[3:0], 12'hA5C, kv[15:0]};
    endfunction

    function automatic logic [31:0] mk(bit halt, int src, logic [2:0] dump, logic [2:0] trig);
        logic [31:0] sv = 32'(src);
        return (32'(halt) << 10) | ({28'd0, sv[3:0]} << 6) | (32'(dump) << 3) | 32'(trig);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_sig(int k);
        for (int s = 0; s < 16; s++) sig_bus[s*32 +: 32] = gen(s, k);
    endtask

    // Starts and ends on a falling edge.
    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    // n samples captured: k = 0..n-1; the halting write rides on the last one.
    task automatic stream(int n, logic [31:0] halt_word);
        for (int k = 0; k < n; k++) begin
            set_sig(k);
            if (k == n - 1) begin
                reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = halt_word;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
    endtask

    task automatic idle(int n, int base);
        for (int i = 0; i < n; i++) begin
            set_sig(base + i);
            @(negedge clk);
        end
    endtask

    task automatic drain(string req, int src, logic [31:0] msk, int first_k, int cnt);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) begin
            set_sig(2000 + i);
            rd(3'd4, v);
            chk(req, v, (i < cnt) ? (gen(src, first_k + i) & msk) : 32'h0);
        end
        rd(3'd4, v);
        chk("R9 read past end", v, 32'h0);
    endtask

    task automatic run(string req, int src, logic [2:0] dump, logic [2:0] trig,
                       logic [31:0] tv, logic [31:0] tm, logic [31:0] dm,
                       int n, int first_k, int cnt);
        wr(3'd0, mk(1'b1, src, dump, trig));
        wr(3'd1, tv);
        wr(3'd2, tm);
        wr(3'd3, dm);
        wr(3'd0, mk(1'b0, src, dump, trig));
        stream(n, mk(1'b1, src, dump, trig));
        idle(20, 900);
        drain(req, src, dm, first_k, cnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        set_sig(0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(3'd0, v); chk("R1 reset control", v, 32'h0000_0409);
        rd(3'd3, v); chk("R1 reset dump mask", v, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R1 reset trigger value", v, 32'h0);
        rd(3'd4, v); chk("R9 empty buffer after reset", v, 32'h0);

        // R3 R8: record always, 40 samples, latest 32 kept, halted idle ignored
        run("R3 R8 record-always wrap", 5, 3'b001, 3'b001, 32'h0, 32'h0, 32'hFFFF_FFFF, 40, 8, 32);
        // R2 R9 R10: masked lane, partial buffer, restart cleared previous content
        run("R2 R9 R10 masked partial", 3, 3'b001, 3'b001, 32'h0, 32'h0, 32'h0000_FF0F, 10, 0, 10);
        // R4 R7: after trigger on edge at k=20
        run("R4 R7 after-trigger edge", 2, 3'b010, 3'b001, 32'd20, 32'h0000_FFFF, 32'hFFFF_FFFF, 70, 20, 32);
        // R5 R6: until trigger on level match at k=50
        run("R5 R6 until-trigger match", 9, 3'b100, 3'b010, 32'd50, 32'h0000_FFFF, 32'hFFFF_FFFF, 60, 18, 32);
        // R6: after trigger on mismatch, first mismatch k=1
        run("R6 after-trigger mismatch", 1, 3'b010, 3'b100, 32'd0, 32'h0000_FFFF, 32'hFFFF_FFFF, 40, 1, 32);
        // R7: equal at first cycle is no edge, never fires
        run("R7 no edge at restart", 4, 3'b100, 3'b001, 32'd0, 32'h0000_FFFF, 32'hFFFF_FFFF, 40, 8, 32);
        // R5 R10: level match at first cycle stops before any store
        run("R5 R10 immediate stop", 4, 3'b100, 3'b010, 32'd0, 32'h0000_FFFF, 32'hFFFF_FFFF, 40, 0, 0);
        // R6: partial trigger mask, fires at k=0x30
        run("R6 partial trigger mask", 6, 3'b010, 3'b010, 32'h0000_0030, 32'h0000_00F0, 32'hFFFF_FFFF, 90, 48, 32);
        // R11: invalid dump mode stores nothing
        run("R11 invalid dump mode", 7, 3'b011, 3'b010, 32'h0, 32'h0, 32'hFFFF_FFFF, 20, 0, 0);
        // R11: invalid trigger mode with after-trigger stores nothing
        run("R11 invalid trigger mode", 7, 3'b010, 3'b011, 32'h0, 32'h0, 32'hFFFF_FFFF, 20, 0, 0);
        // R11: trigger mode ignored when recording always
        run("R11 trigger ignored in record-always", 15, 3'b001, 3'b000, 32'h0, 32'h0, 32'hFFFF_FFFF, 5, 0, 5);

        // R1: invalid codes kept, reserved bits read zero
        wr(3'd0, 32'hFFFF_F800 | mk(1'b1, 12, 3'b110, 3'b011));
        rd(3'd0, v); chk("R1 control readback", v, mk(1'b1, 12, 3'b110, 3'b011));
        wr(3'd2, 32'h1234_5678);
        rd(3'd2, v); chk("R1 trigger mask readback", v, 32'h1234_5678);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule